// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the bus-facing half of a digital thermometer: a slave on a three-wire serial link made of a select line that enables the slave while high, a serial clock, and one bidirectional data line. All three lines are brought into the system-clock domain through synchronizers, and every bus event is detected there. The system clock must run at least eight times faster than the serial clock. Each transaction opens with an 8-bit command, sent least significant bit first. The command then either writes a fixed-length payload into the high threshold, the low threshold or the configuration register, reads back one of those registers or the temperature input, or fires one of three one-cycle action pulses.

The slave drives the data line only while it is sending read data. It presents the output value together with an enable so that the tristate buffer can sit outside the block. From the two resolution bits of the configuration register it also derives the maximum conversion time, which the conversion engine uses. Temperature sensing, conversion and the thermostat comparison live elsewhere. The temperature arrives here as a plain input.

Top module: `tw_reg_slave`

## Requirements
- R1: Whenever the synchronized select is low, the slave returns to idle, clears its bit counter and stops driving the data line. A transaction cut short this way (in the command, write or read phase) has no effect, and the next transaction decodes from its first bit.
- R2: The command byte and all payloads are shifted least significant bit first. Incoming bits are sampled at the rising edge of the serial clock.
- R3: In a read, each bit is driven (enable high) after a falling edge of the serial clock and held through the next rising edge. The enable drops after that rising edge.
- R4: The action opcodes 8'h5A (start conversion), 8'h5B (stop conversion) and 8'h5F (software reset) each produce exactly one single-cycle pulse on their own output. At most one of the three outputs is high at a time, and bits clocked after the command have no effect.
- R5: A write with opcode 8'h11 (high threshold) or 8'h12 (low threshold) commits after 12 data bits. Opcode 8'h1C (configuration) commits after 8 data bits.
- R6: Data bits clocked after the required count are ignored until select falls.
- R7: If select falls before the required count has arrived, the target register keeps its previous value.
- R8: Read opcodes 8'hA0 (temperature, 12 bits), 8'hA1 (high threshold, 12 bits), 8'hA2 (low threshold, 12 bits) and 8'hAC (configuration, 8 bits) start their payload on the clock right after the command byte. Every further clock then returns 0.
- R9: Any other opcode makes the slave ignore the rest of the transaction with the data line left undriven.
- R10: The conversion-time output equals 375 shifted left by the resolution field, which is configuration bits [3:2] (00 = 9 bits, 01 = 10, 10 = 11, 11 = 12). The unit is a quarter millisecond, so the four settings give 375, 750, 1500 and 3000.
- R11: After reset the high threshold is 12'h3C0, the low threshold is 12'h100 and the configuration is 8'h0C (conversion time 3000). The data enable and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus select, active high, asynchronous |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| sdio_i | input | 1 | Data line as seen at the pad |
| temp_i | input | 12 | Current temperature value |
| sdio_o | output | 1 | Data value to drive onto the line |
| sdio_oe_o | output | 1 | Drive enable for the data line |
| hi_thr_o | output | 12 | High threshold register |
| lo_thr_o | output | 12 | Low threshold register |
| cfg_o | output | 8 | Configuration register |
| conv_qms_o | output | 12 | Maximum conversion time in quarter milliseconds |
| conv_start_o | output | 1 | Start-conversion pulse |
| conv_stop_o | output | 1 | Stop-conversion pulse |
| soft_rst_o | output | 1 | Software-reset pulse |

## Verification
Reads use a temperature and written thresholds with uneven bit patterns, so a reversed bit order or a slip of one position shows up as a wrong bit. Each read runs past the payload, which shows whether the zero padding is correct and whether the configuration read stops at 8 bits. Writes are tried at three lengths. A full-length write commits, a longer one shows whether the extra bits are ignored, and a shorter one aborted by select must leave the register unchanged. Action commands followed by extra clocks, an unknown opcode, a read aborted part way and a command aborted part way show apart pulse generation, the silent ignore path and the restart of the bit counter.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } tw_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_START,
        OP_STOP,
        OP_SRST
    } tw_op_e;

    typedef enum logic [1:0] {
        TG_HI,
        TG_LO,
        TG_CFG,
        TG_TEMP
    } tw_tgt_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[i]};
                end
            end
            assign sync_o[i] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
    import tw_reg_pkg::*;
#(
    parameter int         CNTW     = 4,
    parameter int         DW       = 12,
    parameter int         CFGW     = 8,
    parameter logic [7:0] OPC_RD_T = 8'hA0,
    parameter logic [7:0] OPC_RD_H = 8'hA1,
    parameter logic [7:0] OPC_RD_L = 8'hA2,
    parameter logic [7:0] OPC_RD_C = 8'hAC,
    parameter logic [7:0] OPC_WR_H = 8'h11,
    parameter logic [7:0] OPC_WR_L = 8'h12,
    parameter logic [7:0] OPC_WR_C = 8'h1C,
    parameter logic [7:0] OPC_GO   = 8'h5A,
    parameter logic [7:0] OPC_HALT = 8'h5B,
    parameter logic [7:0] OPC_SRST = 8'h5F
) (
    input  logic [7:0]      opc_i,
    output tw_op_e          op_o,
    output tw_tgt_e         tgt_o,
    output logic [CNTW-1:0] len_o
);

    always_comb begin
        op_o  = OP_NONE;
        tgt_o = TG_TEMP;
        len_o = '0;
        if (opc_i == OPC_RD_T) begin
            op_o  = OP_READ;
            tgt_o = TG_TEMP;
        end else if (opc_i == OPC_RD_H) begin
            op_o  = OP_READ;
            tgt_o = TG_HI;
        end else if (opc_i == OPC_RD_L) begin
            op_o  = OP_READ;
            tgt_o = TG_LO;
        end else if (opc_i == OPC_RD_C) begin
            op_o  = OP_READ;
            tgt_o = TG_CFG;
        end else if (opc_i == OPC_WR_H) begin
            op_o  = OP_WRITE;
            tgt_o = TG_HI;
            len_o = CNTW'(DW);
        end else if (opc_i == OPC_WR_L) begin
            op_o  = OP_WRITE;
            tgt_o = TG_LO;
            len_o = CNTW'(DW);
        end else if (opc_i == OPC_WR_C) begin
            op_o  = OP_WRITE;
            tgt_o = TG_CFG;
            len_o = CNTW'(CFGW);
        end else if (opc_i == OPC_GO) begin
            op_o = OP_START;
        end else if (opc_i == OPC_HALT) begin
            op_o = OP_STOP;
        end else if (opc_i == OPC_SRST) begin
            op_o = OP_SRST;
        end
    end

endmodule

// File: rtl/tw_conv_time.sv
module tw_conv_time #(
    parameter int RW    = 2,
    parameter int QBASE = 375,
    parameter int TW    = 12
) (
    input  logic [RW-1:0] res_i,
    output logic [TW-1:0] qms_o
);

    always_comb begin
        qms_o = TW'(QBASE) << res_i;
    end

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
    import tw_reg_pkg::*;
#(
    parameter int          DW          = 12,
    parameter int          CFGW        = 8,
    parameter int          RES_LSB     = 2,
    parameter int          SYNC_STAGES = 2,
    parameter int          QBASE       = 375,
    parameter logic [11:0] HI_RST      = 12'h3C0,
    parameter logic [11:0] LO_RST      = 12'h100,
    parameter logic [7:0]  CFG_RST     = 8'h0C,
    parameter logic [7:0]  OPC_RD_T    = 8'hA0,
    parameter logic [7:0]  OPC_RD_H    = 8'hA1,
    parameter logic [7:0]  OPC_RD_L    = 8'hA2,
    parameter logic [7:0]  OPC_RD_C    = 8'hAC,
    parameter logic [7:0]  OPC_WR_H    = 8'h11,
    parameter logic [7:0]  OPC_WR_L    = 8'h12,
    parameter logic [7:0]  OPC_WR_C    = 8'h1C,
    parameter logic [7:0]  OPC_GO      = 8'h5A,
    parameter logic [7:0]  OPC_HALT    = 8'h5B,
    parameter logic [7:0]  OPC_SRST    = 8'h5F,
    localparam int         MAXB        = (DW > 8) ? DW : 8,
    localparam int         CNTW        = $clog2(MAXB + 1),
    localparam int         TW          = $clog2(QBASE * 8 + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sel_i,
    input  logic            sck_i,
    input  logic            sdio_i,
    input  logic [DW-1:0]   temp_i,
    output logic            sdio_o,
    output logic            sdio_oe_o,
    output logic [DW-1:0]   hi_thr_o,
    output logic [DW-1:0]   lo_thr_o,
    output logic [CFGW-1:0] cfg_o,
    output logic [TW-1:0]   conv_qms_o,
    output logic            conv_start_o,
    output logic            conv_stop_o,
    output logic            soft_rst_o
);

    typedef struct packed {
        tw_state_e       st;
        tw_tgt_e         tgt;
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] need;
        logic [7:0]      cmd;
        logic [DW-1:0]   sh;
        logic [DW-1:0]   hi;
        logic [DW-1:0]   lo;
        logic [CFGW-1:0] cfg;
        logic            sck_prev;
        logic            dout;
        logic            oe;
        logic            p_go;
        logic            p_halt;
        logic            p_srst;
    } slave_t;

    localparam slave_t RST_VAL = '{
        st:       ST_IDLE,
        tgt:      TG_TEMP,
        cnt:      '0,
        need:     '0,
        cmd:      '0,
        sh:       '0,
        hi:       DW'(HI_RST),
        lo:       DW'(LO_RST),
        cfg:      CFGW'(CFG_RST),
        sck_prev: 1'b0,
        dout:     1'b0,
        oe:       1'b0,
        p_go:     1'b0,
        p_halt:   1'b0,
        p_srst:   1'b0
    };

    slave_t q, d;

    logic [2:0] sync_lines;
    logic       sel_s, sck_s, din_s;
    logic       sck_rise, sck_fall;
    logic [7:0] cmd_nx;
    tw_op_e     dec_op;
    tw_tgt_e    dec_tgt;
    logic [CNTW-1:0] dec_len;
    logic [DW-1:0]   wr_nx;

    tw_sync #(
        .N      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({sdio_i, sck_i, sel_i}),
        .sync_o  (sync_lines)
    );

    assign sel_s    = sync_lines[0];
    assign sck_s    = sync_lines[1];
    assign din_s    = sync_lines[2];
    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;
    assign cmd_nx   = {din_s, q.cmd[7:1]};

    tw_cmd_decode #(
        .CNTW     (CNTW),
        .DW       (DW),
        .CFGW     (CFGW),
        .OPC_RD_T (OPC_RD_T),
        .OPC_RD_H (OPC_RD_H),
        .OPC_RD_L (OPC_RD_L),
        .OPC_RD_C (OPC_RD_C),
        .OPC_WR_H (OPC_WR_H),
        .OPC_WR_L (OPC_WR_L),
        .OPC_WR_C (OPC_WR_C),
        .OPC_GO   (OPC_GO),
        .OPC_HALT (OPC_HALT),
        .OPC_SRST (OPC_SRST)
    ) u_dec (
        .opc_i (cmd_nx),
        .op_o  (dec_op),
        .tgt_o (dec_tgt),
        .len_o (dec_len)
    );

    tw_conv_time #(
        .RW    (2),
        .QBASE (QBASE),
        .TW    (TW)
    ) u_conv (
        .res_i (q.cfg[RES_LSB+1:RES_LSB]),
        .qms_o (conv_qms_o)
    );

    always_comb begin
        wr_nx = q.sh;
        wr_nx[q.cnt] = din_s;
    end

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        d.p_go     = 1'b0;
        d.p_halt   = 1'b0;
        d.p_srst   = 1'b0;
        if (!sel_s) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                    d.cmd = '0;
                end
                ST_CMD: begin
                    if (sck_rise) begin
                        d.cmd = cmd_nx;
                        if (q.cnt == CNTW'(7)) begin
                            d.cnt = '0;
                            d.sh  = '0;
                            d.tgt = dec_tgt;
                            unique case (dec_op)
                                OP_READ: begin
                                    d.st = ST_RD;
                                    unique case (dec_tgt)
                                        TG_HI:   d.sh = q.hi;
                                        TG_LO:   d.sh = q.lo;
                                        TG_CFG:  d.sh = DW'(q.cfg);
                                        default: d.sh = temp_i;
                                    endcase
                                end
                                OP_WRITE: begin
                                    d.st   = ST_WR;
                                    d.need = dec_len;
                                end
                                OP_START: begin
                                    d.st   = ST_DONE;
                                    d.p_go = 1'b1;
                                end
                                OP_STOP: begin
                                    d.st     = ST_DONE;
                                    d.p_halt = 1'b1;
                                end
                                OP_SRST: begin
                                    d.st     = ST_DONE;
                                    d.p_srst = 1'b1;
                                end
                                default: d.st = ST_DONE;
                            endcase
                        end else begin
                            d.cnt = q.cnt + CNTW'(1);
                        end
                    end
                end
                ST_WR: begin
                    if (sck_rise) begin
                        d.sh  = wr_nx;
                        d.cnt = q.cnt + CNTW'(1);
                        if (q.cnt == q.need - CNTW'(1)) begin
                            d.st = ST_DONE;
                            unique case (q.tgt)
                                TG_HI:   d.hi  = wr_nx;
                                TG_LO:   d.lo  = wr_nx;
                                TG_CFG:  d.cfg = wr_nx[CFGW-1:0];
                                default: d.st  = ST_DONE;
                            endcase
                        end
                    end
                end
                ST_RD: begin
                    if (sck_fall) begin
                        d.dout = q.sh[0];
                        d.oe   = 1'b1;
                        d.sh   = q.sh >> 1;
                    end else if (sck_rise) begin
                        d.oe = 1'b0;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign sdio_o       = q.dout;
    assign sdio_oe_o    = q.oe;
    assign hi_thr_o     = q.hi;
    assign lo_thr_o     = q.lo;
    assign cfg_o        = q.cfg;
    assign conv_start_o = q.p_go;
    assign conv_stop_o  = q.p_halt;
    assign soft_rst_o   = q.p_srst;

    // R1: deselect releases the data line on the next cycle
    a_r1_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_s |=> !sdio_oe_o);

    // R3: a rising serial-clock edge ends the drive window
    a_r3_release_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sck_rise |=> !sdio_oe_o);

    // R3: in the read phase a falling edge starts driving
    a_r3_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_s && q.st == ST_RD && sck_fall) |=> sdio_oe_o);

    // R4: pulses are mutually exclusive
    a_r4_pulse_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({conv_start_o, conv_stop_o, soft_rst_o}));

    // R4: every pulse lasts a single cycle
    a_r4_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_start_o || conv_stop_o || soft_rst_o) |=>
            !(conv_start_o || conv_stop_o || soft_rst_o));

    // R7: registers cannot change while deselected
    a_r7_hold_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_s |=> ($stable(hi_thr_o) && $stable(lo_thr_o) && $stable(cfg_o)));

    // R9: an ignored transaction never drives the line
    a_r9_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_DONE) |=> !sdio_oe_o);

endmodule

// File: tb/tw_reg_slave_tb.sv
module tw_reg_slave_tb_top;

    localparam logic [11:0] HI_DEF  = 12'h3C0;
    localparam logic [11:0] LO_DEF  = 12'h100;
    localparam logic [7:0]  CFG_DEF = 8'h0C;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, sel, sck, din;
    logic [11:0] temp;
    logic        dout, oe, p_go, p_halt, p_srst;
    logic [11:0] hi, lo, qms;
    logic [7:0]  cfg;

    tw_reg_slave dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sel_i        (sel),
        .sck_i        (sck),
        .sdio_i       (din),
        .temp_i       (temp),
        .sdio_o       (dout),
        .sdio_oe_o    (oe),
        .hi_thr_o     (hi),
        .lo_thr_o     (lo),
        .cfg_o        (cfg),
        .conv_qms_o   (qms),
        .conv_start_o (p_go),
        .conv_stop_o  (p_halt),
        .soft_rst_o   (p_srst)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] m_hi = HI_DEF;
    logic [11:0] m_lo = LO_DEF;
    logic [7:0]  m_cfg = CFG_DEF;
    int settle = 0;
    int cnt_go = 0, cnt_halt = 0, cnt_srst = 0, cnt_oe = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_bit(input logic b);
        din = b;
        wait_n(8);
        sck = 1'b1;
        wait_n(8);
        sck = 1'b0;
    endtask

    task automatic sel_on();
        sel = 1'b1;
        wait_n(6);
    endtask

    task automatic sel_off();
        sck = 1'b0;
        sel = 1'b0;
        wait_n(8);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) sclk_bit(v[i]);
    endtask

    // kind: 0 high threshold, 1 low threshold, 2 configuration
    task automatic wr(input logic [7:0] op, input logic [15:0] val, input int nbits, input int kind);
        int need;
        need = (kind == 2) ? 8 : 12;
        sel_on();
        send_byte(op);
        for (int i = 0; i < nbits; i++) begin
            if (i == need - 1) begin
                settle = 24;
                if (kind == 0) m_hi = val[11:0];
                else if (kind == 1) m_lo = val[11:0];
                else m_cfg = val[7:0];
            end
            sclk_bit(val[i]);
        end
        sel_off();
    endtask

    task automatic rd(input logic [7:0] op, input logic [15:0] exp, input int nbits, input string req);
        sel_on();
        send_byte(op);
        for (int i = 0; i < nbits; i++) begin
            wait_n(8);
            chk(oe === 1'b1 && dout === exp[i], req, {oe, dout}, {1'b1, exp[i]});
            sck = 1'b1;
            wait_n(8);
            chk(oe === 1'b0, {req, " R3 release"}, oe, 0);
            sck = 1'b0;
        end
        sel_off();
    endtask

    // cycle-by-cycle comparison against the behavioural register model
    always @(negedge clk) begin
        if (rst_n) begin
            if (oe) cnt_oe++;
            if (p_go) cnt_go++;
            if (p_halt) cnt_halt++;
            if (p_srst) cnt_srst++;
            if (p_go || p_halt || p_srst)
                chk($countones({p_go, p_halt, p_srst}) == 1, "R4 onehot pulses",
                    {p_go, p_halt, p_srst}, 1);
            if (settle > 0) begin
                settle--;
            end else begin
                chk(hi == m_hi, "R5 high threshold model", hi, m_hi);
                chk(lo == m_lo, "R5 low threshold model", lo, m_lo);
                chk(cfg == m_cfg, "R5 configuration model", cfg, m_cfg);
                chk(qms == (12'd375 << m_cfg[3:2]), "R10 conversion time", qms,
                    12'd375 << m_cfg[3:2]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int g0, h0, s0;
        rst_n = 1'b0; sel = 1'b0; sck = 1'b0; din = 1'b0; temp = 12'hA5C;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        // R11 reset state
        chk(hi == HI_DEF, "R11 high threshold reset", hi, HI_DEF);
        chk(lo == LO_DEF, "R11 low threshold reset", lo, LO_DEF);
        chk(cfg == CFG_DEF, "R11 configuration reset", cfg, CFG_DEF);
        chk(qms == 12'd3000, "R11 conversion time reset", qms, 3000);
        chk(oe == 1'b0 && !p_go && !p_halt && !p_srst, "R11 idle outputs",
            {oe, p_go, p_halt, p_srst}, 0);

        // R2 R8 temperature read, 12 bits then zero padding
        rd(8'hA0, 16'h0A5C, 16, "R8 temperature read");

        // R5 R6 high threshold with 4 extra bits ignored
        wr(8'h11, 16'hF5A3, 16, 0);
        chk(hi == 12'h5A3, "R6 extra bits ignored", hi, 12'h5A3);
        rd(8'hA1, 16'h05A3, 16, "R8 high threshold read");

        // R7 short write aborted
        wr(8'h12, 16'h0071, 7, 1);
        chk(lo == LO_DEF, "R7 short write discarded", lo, LO_DEF);

        // R5 full low threshold write
        wr(8'h12, 16'h00F1, 12, 1);
        chk(lo == 12'h0F1, "R5 low threshold write", lo, 12'h0F1);

        // R10 resolution settings
        wr(8'h1C, 16'h0003, 8, 2);
        chk(qms == 12'd375, "R10 nine-bit time", qms, 375);
        wr(8'h1C, 16'hFF08, 16, 2);
        chk(cfg == 8'h08, "R6 configuration extra bits ignored", cfg, 8'h08);
        chk(qms == 12'd1500, "R10 eleven-bit time", qms, 1500);
        rd(8'hAC, 16'h0008, 12, "R8 configuration read");

        // R4 action commands, trailing bits without effect
        g0 = cnt_go; h0 = cnt_halt; s0 = cnt_srst;
        sel_on(); send_byte(8'h5A); for (int i = 0; i < 12; i++) sclk_bit(1'b1); sel_off();
        chk(cnt_go == g0 + 1 && cnt_halt == h0 && cnt_srst == s0, "R4 start pulse",
            cnt_go - g0, 1);
        sel_on(); send_byte(8'h5B); for (int i = 0; i < 12; i++) sclk_bit(1'b0); sel_off();
        chk(cnt_halt == h0 + 1 && cnt_go == g0 + 1, "R4 stop pulse", cnt_halt - h0, 1);
        sel_on(); send_byte(8'h5F); for (int i = 0; i < 12; i++) sclk_bit(1'b1); sel_off();
        chk(cnt_srst == s0 + 1 && cnt_halt == h0 + 1, "R4 reset pulse", cnt_srst - s0, 1);
        chk(hi == 12'h5A3 && lo == 12'h0F1, "R4 no data phase", hi, 12'h5A3);

        // R9 unknown opcode never drives
        cnt_oe = 0;
        sel_on(); send_byte(8'h00); for (int i = 0; i < 16; i++) sclk_bit(1'b1); sel_off();
        chk(cnt_oe == 0, "R9 unknown opcode silent", cnt_oe, 0);
        chk(hi == 12'h5A3, "R9 unknown opcode no write", hi, 12'h5A3);

        // R1 read aborted part way
        sel_on(); send_byte(8'hA0);
        for (int i = 0; i < 3; i++) sclk_bit(1'b0);
        wait_n(8);
        chk(oe == 1'b1, "R1 driving before abort", oe, 1);
        sel = 1'b0;
        wait_n(8);
        chk(oe == 1'b0, "R1 release on deselect", oe, 0);

        // R1 command aborted part way, next transaction decodes cleanly
        sel_on();
        for (int i = 0; i < 4; i++) sclk_bit(1'b1);
        sel_off();
        rd(8'hA2, 16'h00F1, 14, "R1 counter restart");

        summary();
        $finish;
    end

endmodule